// File: doc/BRIEF.md
# Host-to-Local Read DMA Engine

This block moves a contiguous region of host memory into local device RAM. Software sets three configuration registers over a simple register write port: a local destination byte address, a host source byte address, and a byte count. It then writes a one to the control register. From then on the engine runs by itself. It cuts the region into memory read requests, issues them on a valid/ready request port, and places each returned completion word into local RAM through a write port.

Each request carries a host address, a length in 32-bit words, and a tag chosen by the engine. Completion words come back on a separate port, one word per cycle, labelled with the tag of the request they answer. Words of different requests may interleave. The words of one request arrive in order. A small tag table remembers where in the transfer each outstanding request belongs, so every word lands at its proper local address no matter which request it answers. When the last word has been written, a one-cycle interrupt pulse tells the host that the transfer is finished.

Requests are limited in two ways. None is longer than a maximum read size set by parameter, and none crosses a 4 KB host address boundary. A transfer of fewer than four bytes completes at once and issues no request.

Top module: `dma_rd_engine`

## Requirements
- R1: Register select 0 holds the local destination address, 1 the host source address, 2 the byte count and 3 the control register. Reading selects 0 to 2 returns the written value with bits [1:0] cleared. Reading select 3 returns the busy flag in bit 0 and zero elsewhere. All of them read zero after reset.
- R2: A write to select 3 with bit 0 set, made while idle, starts a transfer and sets busy on the next cycle. A write to select 3 with bit 0 clear starts nothing.
- R3: While busy, writes to every register are ignored, including further start writes. The programmed values read back unchanged and the transfer is not restarted.
- R4: Each request has a nonzero length in 32-bit words of at most MAX_RD_BYTES/4. Address, length and tag stay stable while the request waits for ready.
- R5: No request spans a 4 KB host address boundary: the word offset inside the page plus the length is at most 1024.
- R6: The requests cover the source region in ascending address order with no gap or overlap. Their word lengths sum to the byte count divided by four, rounded down. A 32-byte transfer that lies within one page uses exactly one request of 8 words.
- R7: No request reuses a tag that still has words outstanding. At most NTAG requests are outstanding.
- R8: The k-th completion word for a tag is written to local address destination + 4*(word offset of that request within the transfer) + 4*k, one cycle after it is accepted. A completion word whose tag has nothing outstanding causes no RAM write.
- R9: The interrupt is a single-cycle pulse that appears two cycles after the final completion word is presented. Busy is clear in that same cycle.
- R10: A start with a byte count below 4 raises the interrupt two cycles after the start write is presented and issues no request.
- R11: After reset the engine is idle: no request valid, no RAM write, interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted by the link side |
| req_addr | output | HA_W | Host byte address of the request |
| req_len | output | clog2(MAX_RD_BYTES/4)+1 | Request length in 32-bit words |
| req_tag | output | clog2(NTAG) | Request tag |
| cpl_valid | input | 1 | Completion word valid |
| cpl_tag | input | clog2(NTAG) | Tag of the request this word answers |
| cpl_data | input | 32 | Completion data word |
| ram_we | output | 1 | Local RAM write enable |
| ram_addr | output | LA_W | Local RAM byte address |
| ram_wdata | output | 32 | Local RAM write data |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
The main transfer path is tried in five ways. A small 32-byte transfer that sits inside one page separates correct single-request behaviour from splitting that is too eager. A region that starts just below a page boundary separates the page rule from the size cap. Random regions, sizes and destinations, with a link side that stalls and completions that interleave in random tag order, show whether words are placed by their tag offset or simply by arrival order. The last two patterns are a zero-size start and a start with a byte count below four: their interrupt timing must differ from that of a transfer that moves data. Register writes made mid-transfer, a start write with bit 0 clear, and a completion word whose tag is idle test the rules that certain inputs are ignored. Each is checked through register readback, the RAM write port and the request port.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;

    // 32-bit words in one 4 KB host page
    localparam int unsigned PAGE_DW = 1024;

    typedef enum logic [1:0] {
        SEL_DST  = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_SIZE = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    function automatic logic [31:0] min3_u32(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic [31:0] c);
        logic [31:0] m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

    // words left before the next page boundary
    function automatic logic [31:0] page_room_dw(input logic [9:0] dw_in_page);
        return 32'(PAGE_DW) - {22'd0, dw_in_page};
    endfunction

endpackage

// File: rtl/dma_rd_regs.sv
module dma_rd_regs
    import dma_rd_pkg::*;
#(
    parameter int HA_W = 32,
    parameter int LA_W = 16,
    parameter int SZ_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              busy,
    output logic [LA_W-1:0]   dst,
    output logic [HA_W-1:0]   src,
    output logic [SZ_W-3:0]   size_dw,
    output logic              start
);

    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     accept;
    logic     unused_bit1;

    logic [LA_W-3:0] dst_q;
    logic [HA_W-3:0] src_q;
    logic [SZ_W-3:0] size_q;

    assign wsel        = reg_sel_e'(wr_addr);
    assign rsel        = reg_sel_e'(rd_addr);
    assign accept      = wr_en && !busy;
    assign unused_bit1 = wr_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q  <= '0;
            src_q  <= '0;
            size_q <= '0;
        end else if (accept) begin
            case (wsel)
                SEL_DST:  dst_q  <= wr_data[LA_W-1:2];
                SEL_SRC:  src_q  <= wr_data[HA_W-1:2];
                SEL_SIZE: size_q <= wr_data[SZ_W-1:2];
                default:  ;
            endcase
        end
    end

    assign start   = accept && (wsel == SEL_CTRL) && wr_data[0];
    assign dst     = {dst_q, 2'b00};
    assign src     = {src_q, 2'b00};
    assign size_dw = size_q;

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_DST:  rd_data[LA_W-1:0] = dst;
            SEL_SRC:  rd_data[HA_W-1:0] = src;
            SEL_SIZE: rd_data[SZ_W-1:0] = {size_q, 2'b00};
            SEL_CTRL: rd_data[0]        = busy;
            default:  ;
        endcase
    end

    // R3: configuration frozen while a transfer runs
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(dst_q) && $stable(src_q) && $stable(size_q)));

endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter
    import dma_rd_pkg::*;
#(
    parameter int HA_W   = 32,
    parameter int SZ_W   = 20,
    parameter int MAX_DW = 32,
    parameter int NTAG   = 4,
    localparam int LEN_W = $clog2(MAX_DW) + 1,
    localparam int TAG_W = $clog2(NTAG),
    localparam int DW_W  = SZ_W - 2,
    localparam int CA_W  = HA_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HA_W-1:0]   src,
    input  logic [DW_W-1:0]   size_dw,
    input  logic              tag_avail,
    input  logic [TAG_W-1:0]  free_tag,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [HA_W-1:0]   req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic [TAG_W-1:0]  req_tag,
    output logic              alloc,
    output logic [DW_W-1:0]   alloc_off,
    output logic [LEN_W-1:0]  alloc_len
);

    logic [CA_W-1:0]  cur_dw;
    logic [DW_W-1:0]  left_dw;
    logic [DW_W-1:0]  off_dw;
    logic             vq;
    logic [CA_W-1:0]  addr_q;
    logic [LEN_W-1:0] len_q;
    logic [TAG_W-1:0] tag_q;
    logic [LEN_W-1:0] chunk;
    logic [1:0]       unused_src_lo;

    assign unused_src_lo = src[1:0];

    // next request: bounded by what is left, the size cap and the page edge
    always_comb begin
        chunk = LEN_W'(min3_u32(32'(left_dw), 32'(MAX_DW),
                                page_room_dw(cur_dw[9:0])));
    end

    assign alloc     = !vq && (left_dw != '0) && tag_avail && !start;
    assign alloc_off = off_dw;
    assign alloc_len = chunk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_dw  <= '0;
            left_dw <= '0;
            off_dw  <= '0;
            vq      <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            tag_q   <= '0;
        end else if (start) begin
            cur_dw  <= src[HA_W-1:2];
            left_dw <= size_dw;
            off_dw  <= '0;
            vq      <= 1'b0;
        end else begin
            if (alloc) begin
                vq      <= 1'b1;
                addr_q  <= cur_dw;
                len_q   <= chunk;
                tag_q   <= free_tag;
                cur_dw  <= cur_dw + CA_W'(chunk);
                left_dw <= left_dw - DW_W'(chunk);
                off_dw  <= off_dw + DW_W'(chunk);
            end else if (vq && req_ready) begin
                vq <= 1'b0;
            end
        end
    end

    assign req_valid = vq;
    assign req_addr  = {addr_q, 2'b00};
    assign req_len   = len_q;
    assign req_tag   = tag_q;

    // R4: length within the cap and never zero
    a_r4_len_cap: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len != '0) && (req_len <= LEN_W'(MAX_DW)));

    // R4: request fields hold while stalled
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_len) && $stable(req_tag)));

    // R5: no request crosses a page edge
    a_r5_page: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((32'(req_addr[11:2]) + 32'(req_len)) <= 32'(PAGE_DW)));

endmodule

// File: rtl/dma_rd_tags.sv
module dma_rd_tags #(
    parameter int LA_W   = 16,
    parameter int SZ_W   = 20,
    parameter int MAX_DW = 32,
    parameter int NTAG   = 4,
    localparam int LEN_W = $clog2(MAX_DW) + 1,
    localparam int TAG_W = $clog2(NTAG),
    localparam int DW_W  = SZ_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [DW_W-1:0]   alloc_off,
    input  logic [LEN_W-1:0]  alloc_len,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [31:0]       cpl_data,
    input  logic [LA_W-1:0]   dst,
    output logic              tag_avail,
    output logic [TAG_W-1:0]  free_tag,
    output logic              beat_acc,
    output logic              ram_we,
    output logic [LA_W-1:0]   ram_addr,
    output logic [31:0]       ram_wdata
);

    typedef struct packed {
        logic             busy;
        logic [DW_W-1:0]  base;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] idx;
    } slot_t;

    slot_t            slot_q [NTAG];
    logic [NTAG-1:0]  busy_vec;
    logic [NTAG-1:0]  hit_alloc;
    logic [NTAG-1:0]  hit_beat;
    logic             we_q;
    logic [LA_W-1:0]  addr_q;
    logic [31:0]      data_q;

    for (genvar g = 0; g < NTAG; g++) begin : g_slot
        assign busy_vec[g]  = slot_q[g].busy;
        assign hit_alloc[g] = alloc && (alloc_tag == TAG_W'(g));
        assign hit_beat[g]  = beat_acc && (cpl_tag == TAG_W'(g));
    end

    assign beat_acc = cpl_valid && busy_vec[cpl_tag];

    // lowest free tag
    always_comb begin
        free_tag  = '0;
        tag_avail = 1'b0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                free_tag  = TAG_W'(i);
                tag_avail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAG; i++) slot_q[i] <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            for (int i = 0; i < NTAG; i++) begin
                if (hit_alloc[i]) begin
                    slot_q[i].busy <= 1'b1;
                    slot_q[i].base <= alloc_off;
                    slot_q[i].left <= alloc_len;
                    slot_q[i].idx  <= '0;
                end else if (hit_beat[i]) begin
                    slot_q[i].idx  <= slot_q[i].idx + LEN_W'(1);
                    slot_q[i].left <= slot_q[i].left - LEN_W'(1);
                    if (slot_q[i].left == LEN_W'(1)) slot_q[i].busy <= 1'b0;
                end
            end
            we_q <= beat_acc;
            if (beat_acc) begin
                addr_q <= dst + LA_W'({32'(slot_q[cpl_tag].base)
                                       + 32'(slot_q[cpl_tag].idx), 2'b00});
                data_q <= cpl_data;
            end
        end
    end

    assign ram_we    = we_q;
    assign ram_addr  = addr_q;
    assign ram_wdata = data_q;

    // R7: a tag is only handed out when it has nothing outstanding
    a_r7_alloc_free: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy_vec[alloc_tag]);

    // R8: a word for an idle tag never reaches RAM
    a_r8_stray_word: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !busy_vec[cpl_tag]) |=> !ram_we);

endmodule

// File: rtl/dma_rd_engine.sv
module dma_rd_engine
    import dma_rd_pkg::*;
#(
    parameter int HA_W         = 32,
    parameter int LA_W         = 16,
    parameter int SZ_W         = 20,
    parameter int MAX_RD_BYTES = 128,
    parameter int NTAG         = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              reg_wr_en,
    input  logic [1:0]                        reg_wr_addr,
    input  logic [31:0]                       reg_wr_data,
    input  logic [1:0]                        reg_rd_addr,
    output logic [31:0]                       reg_rd_data,
    output logic                              req_valid,
    input  logic                              req_ready,
    output logic [HA_W-1:0]                   req_addr,
    output logic [$clog2(MAX_RD_BYTES/4):0]   req_len,
    output logic [$clog2(NTAG)-1:0]           req_tag,
    input  logic                              cpl_valid,
    input  logic [$clog2(NTAG)-1:0]           cpl_tag,
    input  logic [31:0]                       cpl_data,
    output logic                              ram_we,
    output logic [LA_W-1:0]                   ram_addr,
    output logic [31:0]                       ram_wdata,
    output logic                              irq
);

    localparam int MAX_DW = MAX_RD_BYTES / 4;
    localparam int LEN_W  = $clog2(MAX_DW) + 1;
    localparam int TAG_W  = $clog2(NTAG);
    localparam int DW_W   = SZ_W - 2;

    logic              busy_q;
    logic              irq_q;
    logic [DW_W-1:0]   dw_left;
    logic              start;
    logic [LA_W-1:0]   dst;
    logic [HA_W-1:0]   src;
    logic [DW_W-1:0]   size_dw;
    logic              tag_avail;
    logic [TAG_W-1:0]  free_tag;
    logic              alloc;
    logic [DW_W-1:0]   alloc_off;
    logic [LEN_W-1:0]  alloc_len;
    logic              beat_acc;

    dma_rd_regs #(.HA_W(HA_W), .LA_W(LA_W), .SZ_W(SZ_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .busy    (busy_q),
        .dst     (dst),
        .src     (src),
        .size_dw (size_dw),
        .start   (start)
    );

    dma_rd_splitter #(.HA_W(HA_W), .SZ_W(SZ_W), .MAX_DW(MAX_DW), .NTAG(NTAG)) u_split (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src       (src),
        .size_dw   (size_dw),
        .tag_avail (tag_avail),
        .free_tag  (free_tag),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_tag   (req_tag),
        .alloc     (alloc),
        .alloc_off (alloc_off),
        .alloc_len (alloc_len)
    );

    dma_rd_tags #(.LA_W(LA_W), .SZ_W(SZ_W), .MAX_DW(MAX_DW), .NTAG(NTAG)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .alloc     (alloc),
        .alloc_tag (free_tag),
        .alloc_off (alloc_off),
        .alloc_len (alloc_len),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .cpl_data  (cpl_data),
        .dst       (dst),
        .tag_avail (tag_avail),
        .free_tag  (free_tag),
        .beat_acc  (beat_acc),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    // transfer progress: words still expected from the host
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            irq_q   <= 1'b0;
            dw_left <= '0;
        end else begin
            irq_q <= 1'b0;
            if (start) begin
                busy_q  <= 1'b1;
                dw_left <= size_dw;
            end else if (busy_q && (dw_left == '0)) begin
                busy_q <= 1'b0;
                irq_q  <= 1'b1;
            end else if (beat_acc) begin
                dw_left <= dw_left - DW_W'(1);
            end
        end
    end

    assign irq = irq_q;

    // R2: a start write always leads to busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_q);

    // R9: interrupt is a single-cycle pulse
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9: engine is idle when the interrupt fires
    a_r9_irq_idle: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy_q);

    // R11: nothing leaves an idle engine
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !$past(busy_q)) |-> !req_valid);

endmodule

// File: tb/dma_rd_engine_test.sv
`timescale 1ns/1ps
module dma_rd_engine_test;

    localparam int HA_W   = 32;
    localparam int LA_W   = 16;
    localparam int SZ_W   = 20;
    localparam int MAXB   = 128;
    localparam int MAX_DW = MAXB / 4;
    localparam int NTAG   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [5:0]  req_len;
    logic [1:0]  req_tag;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_tag = '0;
    logic [31:0] cpl_data = '0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [31:0] ram_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] lmem [int];
    bit          o_valid [NTAG];
    logic [31:0] o_addr [NTAG];
    int          o_len [NTAG];
    int          o_sent [NTAG];

    always #2.5 clk = ~clk;

    dma_rd_engine #(.HA_W(HA_W), .LA_W(LA_W), .SZ_W(SZ_W),
                    .MAX_RD_BYTES(MAXB), .NTAG(NTAG)) uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq(irq)
    );

    function automatic logic [31:0] hostdata(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic int exp_reqs(input logic [31:0] src, input int ndw);
        logic [31:0] a;
        int n, left, room, c;
        a = src & ~32'd3;
        left = ndw;
        n = 0;
        while (left > 0) begin
            room = 1024 - int'(a[11:2]);
            c = left;
            if (c > MAX_DW) c = MAX_DW;
            if (c > room) c = room;
            a = a + 32'(c * 4);
            left = left - c;
            n++;
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #0.5;
        d = reg_rd_data;
    endtask

    // one complete transfer against a responding host model
    task automatic run_xfer(input logic [31:0] dst, input logic [31:0] src,
                            input logic [31:0] size, input bit poke,
                            input int ready_pct, input int beat_pct);
        logic [31:0] exp_next, rd, la;
        int ndw, sent_dw, req_dw, nreq, nwr, cyc, last_cyc, pick, st, t, new_tag;
        bit got_irq, bad_seq, bad_len, bad_page, bad_tag;
        exp_next = src & ~32'd3;
        ndw = int'(size[SZ_W-1:2]);
        sent_dw = 0; req_dw = 0; nreq = 0; nwr = 0; cyc = 0; last_cyc = -10;
        got_irq = 0; bad_seq = 0; bad_len = 0; bad_page = 0; bad_tag = 0;
        lmem.delete();
        for (int i = 0; i < NTAG; i++) o_valid[i] = 0;
        write_reg(2'd0, dst);
        write_reg(2'd1, src);
        write_reg(2'd2, size);
        write_reg(2'd3, 32'd1);
        if (poke) begin
            write_reg(2'd0, 32'h0000_FFF0);
            write_reg(2'd2, 32'd0);
            write_reg(2'd3, 32'd1);
        end
        while (!got_irq && cyc < 20000) begin
            if (ram_we) begin
                lmem[int'(ram_addr)] = ram_wdata;
                nwr++;
            end
            if (irq) begin
                got_irq = 1;
                break;
            end
            req_ready = (($urandom % 100) < ready_pct);
            new_tag = -1;
            if (req_valid && req_ready) begin
                if (req_addr != exp_next) bad_seq = 1;
                if (req_len == 0 || req_len > MAX_DW) bad_len = 1;
                if (int'(req_addr[11:2]) + int'(req_len) > 1024) bad_page = 1;
                if (o_valid[req_tag]) bad_tag = 1;
                exp_next = exp_next + 32'(req_len) * 4;
                req_dw += int'(req_len);
                nreq++;
                new_tag = int'(req_tag);
                o_addr[req_tag] = req_addr;
                o_len[req_tag]  = int'(req_len);
                o_sent[req_tag] = 0;
            end
            cpl_valid = 1'b0;
            pick = -1;
            if (($urandom % 100) < beat_pct) begin
                st = int'($urandom % NTAG);
                for (int k = 0; k < NTAG; k++) begin
                    t = (st + k) % NTAG;
                    if (o_valid[t] && pick < 0) pick = t;
                end
            end
            if (pick >= 0) begin
                cpl_valid = 1'b1;
                cpl_tag   = 2'(pick);
                cpl_data  = hostdata(o_addr[pick] + 32'(o_sent[pick] * 4));
                o_sent[pick]++;
                sent_dw++;
                if (o_sent[pick] == o_len[pick]) o_valid[pick] = 0;
                if (sent_dw == ndw) last_cyc = cyc;
            end
            if (new_tag >= 0) o_valid[new_tag] = 1;
            @(negedge clk);
            cyc++;
        end
        req_ready = 1'b0;
        cpl_valid = 1'b0;
        check(got_irq, "R9", "interrupt seen", 32'(got_irq), 32'd1);
        if (ndw == 0)
            check(cyc == 1, "R10", "zero-size irq cycle", 32'(cyc), 32'd1);
        else
            check(cyc == last_cyc + 2, "R9", "irq latency after last word",
                  32'(cyc), 32'(last_cyc + 2));
        read_reg(2'd3, rd);
        check(rd[0] == 1'b0, "R9", "busy clear with irq", rd, 32'd0);
        check(!bad_seq, "R6", "requests contiguous", 32'(bad_seq), 32'd0);
        check(!bad_len, "R4", "request length cap", 32'(bad_len), 32'd0);
        check(!bad_page, "R5", "no page crossing", 32'(bad_page), 32'd0);
        check(!bad_tag, "R7", "tag unique among outstanding", 32'(bad_tag), 32'd0);
        check(req_dw == ndw, "R6", "words requested", 32'(req_dw), 32'(ndw));
        check(nreq == exp_reqs(src, ndw), "R6", "request count",
              32'(nreq), 32'(exp_reqs(src, ndw)));
        check(nwr == ndw, "R8", "RAM write count", 32'(nwr), 32'(ndw));
        for (int i = 0; i < ndw; i++) begin
            la = 32'(16'(dst[15:0] & 16'hFFFC) + 16'(i * 4));
            if (!lmem.exists(int'(la)))
                check(0, "R8", "missing RAM word at", la, la);
            else if (lmem[int'(la)] != hostdata((src & ~32'd3) + 32'(i * 4)))
                check(0, "R8", "RAM word value", lmem[int'(la)],
                      hostdata((src & ~32'd3) + 32'(i * 4)));
        end
        check(1, "R8", "RAM contents compared", 0, 0);
        if (poke) begin
            read_reg(2'd0, rd);
            check(rd == (dst & 32'h0000_FFFC), "R3", "dst unchanged after busy write",
                  rd, dst & 32'h0000_FFFC);
            read_reg(2'd2, rd);
            check(rd == (size & 32'h000F_FFFC), "R3", "size unchanged after busy write",
                  rd, size & 32'h000F_FFFC);
        end
        @(negedge clk);
        check(!irq, "R9", "irq single cycle", 32'(irq), 32'd0);
        req_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!req_valid, "R3", "no restart after done", 32'(req_valid), 32'd0);
        req_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, d, s, z;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 / R1: reset state
        check(!req_valid && !ram_we && !irq, "R11", "idle outputs after reset",
              {29'd0, req_valid, ram_we, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            read_reg(2'(a), rd);
            check(rd == 32'd0, "R1", "register zero after reset", rd, 32'd0);
        end

        // R1: readback with low bits cleared
        write_reg(2'd0, 32'h0000_1237);
        write_reg(2'd1, 32'hABCD_0123);
        write_reg(2'd2, 32'h0000_0043);
        read_reg(2'd0, rd); check(rd == 32'h0000_1234, "R1", "dst readback", rd, 32'h1234);
        read_reg(2'd1, rd); check(rd == 32'hABCD_0120, "R1", "src readback", rd, 32'hABCD_0120);
        read_reg(2'd2, rd); check(rd == 32'h0000_0040, "R1", "size readback", rd, 32'h40);

        // R2: control write with bit 0 clear does nothing
        write_reg(2'd3, 32'd2);
        read_reg(2'd3, rd);
        check(rd == 32'd0, "R2", "no start on bit0 clear", rd, 32'd0);
        @(negedge clk);
        check(!irq && !req_valid, "R2", "no activity on bit0 clear",
              {30'd0, irq, req_valid}, 32'd0);

        // R8: stray completion word with an idle tag
        cpl_valid = 1'b1; cpl_tag = 2'd2; cpl_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cpl_valid = 1'b0;
        check(!ram_we, "R8", "stray word not written", 32'(ram_we), 32'd0);

        // R2: start sets busy on the next cycle
        write_reg(2'd0, 32'h0000_0100);
        write_reg(2'd1, 32'h0000_2000);
        write_reg(2'd2, 32'd8);
        write_reg(2'd3, 32'd1);
        read_reg(2'd3, rd);
        check(rd[0] == 1'b1, "R2", "busy after start", rd, 32'd1);
        cpl_valid = 1'b0; req_ready = 1'b1;
        repeat (3) @(negedge clk);
        req_ready = 1'b0;
        // finish it: two words outstanding under the tag just issued
        cpl_valid = 1'b1; cpl_tag = 2'd0; cpl_data = 32'h1;
        @(negedge clk);
        cpl_data = 32'h2;
        @(negedge clk);
        cpl_valid = 1'b0;
        repeat (3) @(negedge clk);
        read_reg(2'd3, rd);
        check(rd[0] == 1'b0, "R2", "idle after short transfer", rd, 32'd0);

        // R6: 32 bytes in one page -> one request
        run_xfer(32'h0000_8000, 32'h001F_F000, 32'd32, 0, 100, 100);

        // R5: start just below a page edge
        run_xfer(32'h0000_0400, 32'h0000_0FC0, 32'd256, 0, 100, 60);

        // R10: zero size and sub-word size
        run_xfer(32'h0000_0200, 32'h0000_3000, 32'd0, 0, 100, 100);
        run_xfer(32'h0000_0200, 32'h0000_3000, 32'd3, 0, 100, 100);

        // R3: writes while busy are ignored
        run_xfer(32'h0000_1000, 32'h0004_0F80, 32'd400, 1, 70, 50);

        // random transfers with stalls and interleaving
        for (int n = 0; n < 20; n++) begin
            d = ($urandom % 32'h8000) & ~32'd3;
            s = $urandom & 32'h00FF_FFFF;
            z = 32'($urandom % 1500);
            run_xfer(d, s, z, 0, 30 + int'($urandom % 71), 20 + int'($urandom % 81));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule